// File: doc/BRIEF.md
# Statistical Operation Sample Selector

This block decides which operation in a stream of dispatched or retiring operations is chosen for detailed profiling. It counts eligible operations down from a programmable interval; the eligible operation that brings the count to its end is chosen, and in that same cycle the block raises a tag pulse that the pipeline attaches to that operation. The count then reloads. With jitter enabled, a small pseudo-random amount is added to each reload. This keeps the sampling from locking onto loops whose period matches the interval.

Only one chosen operation may be outstanding. A busy flag stays high from a tag until the completion strobe for that operation arrives. If the count runs out while the flag is high, the choice is discarded and a saturating collision counter is incremented. That count covers every discarded choice, whatever a later filter would have done with it. A mode input sets what counts as eligible: every micro-operation, or only the first micro-operation of each architectural instruction.

Top module: `samp_selector`

## Requirements
- R1: The interval register resets to MIN_IVAL (default 8). A write with a value below MIN_IVAL stores MIN_IVAL. A write at or above it stores the value unchanged.
- R2: Without jitter, after a reload to N, the N-th following eligible operation is chosen. An operation is chosen in the cycle its op_valid is high, and sample_tag is asserted combinationally in that same cycle when the choice is accepted.
- R3: With count_mode=1 every op_valid operation is eligible. With count_mode=0 only operations with op_first=1 are eligible. Operations that are not eligible leave the count unchanged.
- R4: The 16-bit LFSR resets to 0xACE1. On each step the bits are shifted up one place, and bit 0 takes bit15^bit13^bit12^bit10. It steps once per expiry, whether or not the choice is accepted. At an expiry with jitter_en=1 the reload is the interval plus LFSR bits [3:0] (the value before the step); with jitter_en=0 it is the interval alone. The count after reset is MIN_IVAL, with no jitter.
- R5: busy is high from the cycle after a sample_tag until the cycle after a done with no tag in that cycle. A done while idle has no effect.
- R6: An expiry with busy high and done low raises no sample_tag, adds one to coll_count, and still reloads the count.
- R7: An expiry in the same cycle as done is accepted: sample_tag is raised and busy stays high.
- R8: coll_count saturates at all ones (255 for CNT_W=8) instead of wrapping.
- R9: coll_clr sets coll_count to zero on the next edge. It takes priority over a collision in the same cycle.
- R10: A new interval value takes effect at the next reload. The count already running is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_first | input | 1 | The operation is the first micro-op of an instruction |
| count_mode | input | 1 | 1: count all micro-ops; 0: count instructions only |
| done | input | 1 | The chosen operation has completed |
| ival_we | input | 1 | Write enable of the interval register |
| ival_wdata | input | INT_W | Interval value to write |
| jitter_en | input | 1 | Add LFSR jitter to each reload |
| coll_clr | input | 1 | Synchronous clear of the collision counter |
| sample_tag | output | 1 | The current operation is chosen for profiling |
| busy | output | 1 | A chosen operation is outstanding |
| coll_count | output | CNT_W | Saturating number of discarded choices |

## Verification
The bench targets an expiry that lands on the same cycle as done: a design that gives priority to done would drop the choice and count a spurious collision. It drives the collision counter past 255, where a counter that wraps would read zero. It issues a clear in the same cycle as a collision, where a design that gives priority to the increment would leave 1. It writes intervals below the minimum, where a missing clamp would show up as samples spaced too closely. Instruction-only counting with sparse op_first, and jittered reloads checked against an independent LFSR model, expose errors in eligibility and in the order of tap or step.

// File: rtl/samp_selector_pkg.sv
package samp_selector_pkg;

  localparam int          LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  typedef enum logic {
    CNT_ARCH = 1'b0,
    CNT_UOP  = 1'b1
  } cnt_mode_e;

  // maximal-length Fibonacci step, taps 16,14,13,11
  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic op_eligible(input logic vld, input logic first,
                                       input cnt_mode_e mode);
    return vld && ((mode == CNT_UOP) || first);
  endfunction

endpackage

// File: rtl/samp_lfsr.sv
module samp_lfsr #(
  parameter int JIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [JIT_W-1:0] jit_bits
);
  import samp_selector_pkg::*;

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= LFSR_SEED;
    else if (step) state_q <= lfsr_next(state_q);
  end

  assign jit_bits = state_q[JIT_W-1:0];

  logic unused_hi;
  assign unused_hi = ^state_q[LFSR_W-1:JIT_W];

endmodule

// File: rtl/samp_interval.sv
module samp_interval #(
  parameter int INT_W    = 16,
  parameter int JIT_W    = 4,
  parameter int MIN_IVAL = 8,
  localparam int RLD_W   = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eligible,
  input  logic             ival_we,
  input  logic [INT_W-1:0] ival_wdata,
  input  logic             jitter_en,
  input  logic [JIT_W-1:0] jit_bits,
  output logic             expire,
  output logic [RLD_W-1:0] reload_val
);

  localparam logic [INT_W-1:0] MIN_V = INT_W'(MIN_IVAL);

  function automatic logic [INT_W-1:0] clamp_ival(input logic [INT_W-1:0] v);
    return (v < MIN_V) ? MIN_V : v;
  endfunction

  function automatic logic [RLD_W-1:0] reload_calc(input logic [INT_W-1:0] ival,
                                                   input logic             jen,
                                                   input logic [JIT_W-1:0] jb);
    logic [RLD_W-1:0] add;
    add = jen ? RLD_W'(jb) : '0;
    return RLD_W'(ival) + add;
  endfunction

  logic [INT_W-1:0] ival_q;
  logic [RLD_W-1:0] cnt_q;

  assign expire     = eligible && (cnt_q == RLD_W'(1));
  assign reload_val = reload_calc(ival_q, jitter_en, jit_bits);

  always_ff @(posedge clk) begin
    if (!rst_n)       ival_q <= MIN_V;
    else if (ival_we) ival_q <= clamp_ival(ival_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= RLD_W'(MIN_IVAL);
    else if (expire)   cnt_q <= reload_val;
    else if (eligible) cnt_q <= cnt_q - RLD_W'(1);
  end

endmodule

// File: rtl/samp_flight.sv
module samp_flight (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic done,
  output logic accept,
  output logic collide,
  output logic busy
);

  logic busy_q;

  assign accept  = expire && (!busy_q || done);
  assign collide = expire && busy_q && !done;

  always_ff @(posedge clk) begin
    if (!rst_n)      busy_q <= 1'b0;
    else if (accept) busy_q <= 1'b1;
    else if (done)   busy_q <= 1'b0;
  end

  assign busy = busy_q;

endmodule

// File: rtl/samp_collcnt.sv
module samp_collcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == TOP) ? TOP : v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= sat_inc(cnt_q);
  end

  assign count = cnt_q;

endmodule

// File: rtl/samp_selector.sv
module samp_selector #(
  parameter int INT_W      = 16,
  parameter int JIT_W      = 4,
  parameter int MIN_IVAL   = 8,
  parameter int CNT_W      = 8,
  parameter bit HAS_JITTER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_first,
  input  logic             count_mode,
  input  logic             done,
  input  logic             ival_we,
  input  logic [INT_W-1:0] ival_wdata,
  input  logic             jitter_en,
  input  logic             coll_clr,
  output logic             sample_tag,
  output logic             busy,
  output logic [CNT_W-1:0] coll_count
);
  import samp_selector_pkg::*;

  localparam int RLD_W = INT_W + 1;

  logic             elig_w;
  logic             expire_w;
  logic             accept_w;
  logic             collide_w;
  logic [JIT_W-1:0] jit_w;
  logic [RLD_W-1:0] reload_w;

  assign elig_w = op_eligible(op_valid, op_first, cnt_mode_e'(count_mode));

  generate
    if (HAS_JITTER) begin : g_jit
      samp_lfsr #(.JIT_W(JIT_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(expire_w), .jit_bits(jit_w)
      );
    end else begin : g_nojit
      assign jit_w = '0;
    end
  endgenerate

  samp_interval #(.INT_W(INT_W), .JIT_W(JIT_W), .MIN_IVAL(MIN_IVAL)) u_ival (
    .clk(clk), .rst_n(rst_n), .eligible(elig_w), .ival_we(ival_we),
    .ival_wdata(ival_wdata), .jitter_en(jitter_en), .jit_bits(jit_w),
    .expire(expire_w), .reload_val(reload_w)
  );

  samp_flight u_flight (
    .clk(clk), .rst_n(rst_n), .expire(expire_w), .done(done),
    .accept(accept_w), .collide(collide_w), .busy(busy)
  );

  samp_collcnt #(.CNT_W(CNT_W)) u_coll (
    .clk(clk), .rst_n(rst_n), .inc(collide_w), .clr(coll_clr), .count(coll_count)
  );

  assign sample_tag = accept_w;

endmodule

// File: rtl/samp_selector_chk.sv
module samp_selector_chk #(
  parameter int CNT_W    = 8,
  parameter int RLD_W    = 17,
  parameter int MIN_IVAL = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             done,
  input logic             coll_clr,
  input logic             sample_tag,
  input logic             busy,
  input logic [CNT_W-1:0] coll_count,
  input logic             expire,
  input logic             collide,
  input logic [RLD_W-1:0] reload_val
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_EXPIRE_ON_OP: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> op_valid); // R2
  AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (reload_val >= RLD_W'(MIN_IVAL))); // R1
  AST_TAG_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tag |-> (!busy || done)); // R7
  AST_BUSY_AFTER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tag |=> busy); // R5
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sample_tag) |=> !busy); // R5
  AST_COLL_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> !sample_tag); // R6
  AST_COLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !coll_clr && coll_count != TOP) |=>
      coll_count == CNT_W'($past(coll_count) + CNT_W'(1))); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_count == TOP && !coll_clr) |=> coll_count == TOP); // R8
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    coll_clr |=> coll_count == '0); // R9

endmodule

bind samp_selector samp_selector_chk #(
  .CNT_W(CNT_W), .RLD_W(INT_W + 1), .MIN_IVAL(MIN_IVAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .done(done),
  .coll_clr(coll_clr), .sample_tag(sample_tag), .busy(busy),
  .coll_count(coll_count), .expire(expire_w), .collide(collide_w),
  .reload_val(reload_w)
);

// File: tb/samp_selector_bench.sv
module samp_selector_bench;
  localparam int INT_W = 16;
  localparam int MIN_IVAL = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, op_first = 0, count_mode = 1, done = 0;
  logic ival_we = 0, jitter_en = 0, coll_clr = 0;
  logic [INT_W-1:0] ival_wdata = '0;
  logic sample_tag, busy;
  logic [CNT_W-1:0] coll_count;

  always #2 clk = ~clk;

  samp_selector u_samp_selector (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_first(op_first),
    .count_mode(count_mode), .done(done), .ival_we(ival_we),
    .ival_wdata(ival_wdata), .jitter_en(jitter_en), .coll_clr(coll_clr),
    .sample_tag(sample_tag), .busy(busy), .coll_count(coll_count)
  );

  int checks = 0, fails = 0;
  string cur_req = "R2";

  // independent model state
  int unsigned m_int, m_cnt, m_coll;
  logic [15:0] m_lfsr;
  logic m_busy;

  function automatic int unsigned b_clamp(input int unsigned v);
    return (v < MIN_IVAL) ? MIN_IVAL : v;
  endfunction

  function automatic logic [15:0] b_lfsr(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return (s << 1) | 16'(fb);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_int = MIN_IVAL; m_cnt = MIN_IVAL; m_coll = 0; m_lfsr = 16'hACE1; m_busy = 0;
  endtask

  // one cycle: drive at negedge, check outputs, advance model
  task automatic step(input logic v, input logic f, input logic d,
                      input logic we, input int unsigned wv, input logic clr);
    logic elig, ex, acc, col;
    op_valid = v; op_first = f; done = d; ival_we = we; ival_wdata = INT_W'(wv);
    coll_clr = clr;
    #1;
    elig = v && (count_mode || f);
    ex   = elig && (m_cnt == 1);
    acc  = ex && (!m_busy || d);
    col  = ex && m_busy && !d;
    chk(cur_req, "sample_tag", int'(sample_tag), int'(acc));
    chk(cur_req, "busy", int'(busy), int'(m_busy));
    chk(cur_req, "coll_count", int'(coll_count), int'(m_coll));
    if (ex) begin
      m_cnt = m_int + (jitter_en ? int'(m_lfsr[3:0]) : 0);
      m_lfsr = b_lfsr(m_lfsr);
    end else if (elig) m_cnt--;
    if (we) m_int = b_clamp(wv);
    if (acc) m_busy = 1; else if (d) m_busy = 0;
    if (clr) m_coll = 0;
    else if (col && m_coll != 255) m_coll++;
    @(negedge clk);
  endtask

  // ops that finish quickly: done the cycle after a tag
  task automatic run_quick(input int n, input int dense);
    for (int i = 0; i < n; i++) begin
      logic d;
      d = m_busy;
      step(($urandom % 100) < dense, ($urandom % 3) == 0, d, 0, 0, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    cur_req = "R1";
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset coll_count", int'(coll_count), 0);

    // R1: default interval gives tag on eighth op
    begin
      int seen; seen = 0;
      for (int i = 1; i <= 12; i++) begin
        if (sample_tag === 1'b0) begin end
        op_valid = 1; #1;
        if (sample_tag && seen == 0) seen = i;
        #0;
        step(1, 0, m_busy, 0, 0, 0);
      end
      chk("R1", "first tag position", seen, MIN_IVAL);
    end

    // R1 clamp and R10 deferred effect
    cur_req = "R10";
    step(1, 0, m_busy, 1, 3, 0);
    run_quick(40, 100);
    cur_req = "R1";
    begin
      int gap, last, idx; gap = 0; last = -1; idx = 0;
      for (int i = 0; i < 40; i++) begin
        op_valid = 1; #1;
        if (sample_tag) begin
          if (last >= 0) gap = idx - last;
          last = idx;
        end
        idx++;
        step(1, 0, m_busy, 0, 0, 0);
      end
      chk("R1", "clamped spacing", gap, MIN_IVAL);
    end
    cur_req = "R10";
    step(1, 0, m_busy, 1, 20, 0);
    run_quick(80, 100);
    step(1, 0, m_busy, 1, 11, 0);
    run_quick(60, 70);

    // R3: instruction-only counting
    cur_req = "R3";
    count_mode = 0;
    run_quick(300, 90);
    count_mode = 1;
    cur_req = "R2";
    run_quick(200, 60);

    // R4: jitter
    cur_req = "R4";
    jitter_en = 1;
    run_quick(600, 85);
    jitter_en = 0;

    // R6/R8: never complete -> collisions until saturation
    cur_req = "R6";
    step(1, 0, 0, 1, MIN_IVAL, 0);
    for (int i = 0; i < 400; i++) step(1, 0, 0, 0, 0, 0);
    cur_req = "R8";
    for (int i = 0; i < 2000; i++) step(1, 0, 0, 0, 0, 0);
    #1; chk("R8", "saturated count", int'(coll_count), 255);
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 0, 0);
    #1; chk("R8", "no wrap", int'(coll_count), 255);

    // R9: clear coincident with a collision
    cur_req = "R9";
    while (m_cnt != 1) step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1);
    #1; chk("R9", "clear beats collision", int'(coll_count), 0);

    // R7: done on the expiry cycle
    cur_req = "R7";
    while (m_cnt != 1) step(1, 0, 0, 0, 0, 0);
    op_valid = 1; done = 1; #1;
    chk("R7", "tag with done", int'(sample_tag), 1);
    step(1, 0, 1, 0, 0, 0);
    #1; chk("R7", "busy kept", int'(busy), 1);
    chk("R7", "no collision", int'(coll_count), 0);

    // R5: done drops busy; stray done when idle
    cur_req = "R5";
    step(0, 0, 1, 0, 0, 0);
    #1; chk("R5", "busy cleared", int'(busy), 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // random mix
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic we, d, clr;
      we = ($urandom % 200) == 0;
      d  = ($urandom % 5) == 0;
      clr = ($urandom % 300) == 0;
      if (($urandom % 500) == 0) jitter_en = ~jitter_en;
      if (($urandom % 500) == 0) count_mode = ~count_mode;
      step(($urandom % 4) != 0, ($urandom % 2) == 0, d, we, $urandom % 24, clr);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule